// File: doc/BRIEF.md
# Five-Level Page Table Walker

This block turns a 64-bit virtual address into a 56-bit physical address by reading page-table entries from memory one level at a time. A request carries the virtual address, an access code, a level-count select (five or four levels), a guest-stage select and the page number of the root table. The walker issues one 8-byte entry read per level over a valid/ready request channel and takes the answer on a single-cycle response strobe. It finishes with a one-cycle result carrying either the physical address, the low ten bits of the leaf entry and the level the leaf was found at, or a fault flag.

A leaf may sit at any level, so the pages it maps run from 4 KiB up to 256 TiB. The walker checks that a large page is aligned and copies the untranslated low page-number fields from the virtual address. In guest-stage mode the top index field grows by two bits, so the root table is four times the normal size, and faults are reported on a separate flag. The block accepts one request at a time and is meant to sit behind a translation cache that only calls it on a miss.

Top module: `pgwalk_top`

## Requirements
- R1: In five-level mode the index fields are va[56:48], va[47:39], va[38:30], va[29:21] and va[20:12], used from the root downward. Each entry read is at byte address (table page number * 4096) + index * 8, and the first read uses the root page number and the top index.
- R2: A range violation faults with no memory read, and its response is due one cycle after acceptance. In five-level native mode, va[63:57] must all equal va[56]. In four-level native mode, va[63:48] must all equal va[47].
- R3: With the five-level select low, the walk starts at index va[47:39] and reads at most four levels.
- R4: An entry faults if V (bit 0) is clear, if W (bit 2) is set while R (bit 1) is clear, or if any of bits 63:54 is set.
- R5: An entry with R, W and X (bit 3) all clear points to the next table, whose page number is entry bits 53:10. Such a pointer found at the lowest level faults.
- R6: Any level may hold a leaf. For a leaf at level L, the low 9*L bits of the leaf page number must be zero or the walk faults. On success, those bits of the physical address come from the virtual address, the rest from the entry, and the page offset va[11:0] passes through.
- R7: Access code 0 (load) needs R, code 1 (store) needs W and code 2 (fetch) needs X; otherwise the walk faults. A successful result reports entry bits 9:0 and the leaf level.
- R8: With the guest select set, the root index is 11 bits wide (va[58:48] for five levels, va[49:39] for four). Bits above 58 (or 49) must be zero. Every fault in this mode is reported on the guest fault flag instead of the page fault flag.
- R9: Each accepted request gets exactly one response strobe lasting one cycle. The ready output is high only while idle, and requests presented while busy are ignored.
- R10: A memory request stays valid with an unchanged address until the memory side accepts it.
- R11: After reset the walker is ready, with no response strobe and no memory request.
- R12: With memory that accepts at once and answers in the next cycle, the response for a walk of N reads is due 1 + 2N cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual (or guest physical) address |
| req_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch |
| req_five | input | 1 | 1 selects five levels, 0 four levels |
| req_guest | input | 1 | Guest-stage mode with widened root |
| req_root | input | 44 | Root table page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data strobe |
| mem_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_pf | output | 1 | Page fault |
| rsp_gpf | output | 1 | Guest page fault |
| rsp_paddr | output | 56 | Physical address on success |
| rsp_flags | output | 10 | Leaf entry bits 9:0 on success |
| rsp_level | output | 3 | Level of the leaf (0 = 4 KiB) |

## Verification
Every outcome has a known due cycle. A range fault answers one cycle after acceptance, and a walk of N reads answers 1 + 2N cycles after acceptance when memory is ready at once. A held-off memory request delays the answer by exactly the number of refused cycles. The bench counts negative clock edges from acceptance to the result strobe and compares that count with this formula for every case. It also counts the reads that memory served and samples every output at the negative edge. It then checks that the strobe is gone one cycle later.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int PG_OFF_W   = 12;
  localparam int PTE_FLAG_W = 10;
  localparam int PTE_PPN_LSB = 10;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } st_e;
endpackage

// File: rtl/pgwalk_range.sv
// Upper-address legality check, done before any memory read.
module pgwalk_range #(
  parameter int VA_W = 64,
  parameter int OFF_W = 12,
  parameter int IDX_W = 9,
  parameter int ROOT_EXTRA = 2
) (
  input  logic [VA_W-OFF_W-4*IDX_W:0] hi,   // va[VA_W-1 : OFF_W+4*IDX_W-1]
  input  logic                        five,
  input  logic                        guest,
  output logic                        ok
);
  localparam int TOP4 = OFF_W + 4*IDX_W;    // first bit above a four-level address
  localparam int TOP5 = OFF_W + 5*IDX_W;
  localparam int HI_MSB = VA_W - TOP4;
  localparam int N5_LSB = TOP5 - TOP4;      // va[TOP5-1]
  localparam int G5_LSB = TOP5 + ROOT_EXTRA - TOP4 + 1;
  localparam int G4_LSB = ROOT_EXTRA + 1;

  logic n4_ok, n5_ok, g4_ok, g5_ok;

  always_comb begin
    n4_ok = (&hi) | ~(|hi);
    n5_ok = (&hi[HI_MSB:N5_LSB]) | ~(|hi[HI_MSB:N5_LSB]);
    g4_ok = ~(|hi[HI_MSB:G4_LSB]);
    g5_ok = ~(|hi[HI_MSB:G5_LSB]);
    if (guest) ok = five ? g5_ok : g4_ok;
    else       ok = five ? n5_ok : n4_ok;
  end
endmodule

// File: rtl/pgwalk_pte_eval.sv
// Classifies one table entry at a given level and forms the leaf page number.
module pgwalk_pte_eval
  import pgwalk_pkg::*;
#(
  parameter int PA_W = 56,
  parameter int PTE_W = 64,
  parameter int IDX_W = 9,
  parameter int LVL_W = 3
) (
  input  logic [PTE_W-1:0]          pte,
  input  logic [LVL_W-1:0]          lvl,
  input  logic [1:0]                acc,
  input  logic [PA_W-PG_OFF_W-1:0]  vpn,
  output logic                      is_ptr,
  output logic                      fault,
  output logic [PA_W-PG_OFF_W-1:0]  ppn,
  output logic [PA_W-PG_OFF_W-1:0]  leaf_ppn,
  output logic [PTE_FLAG_W-1:0]     flags
);
  localparam int PPN_W   = PA_W - PG_OFF_W;
  localparam int RSV_LSB = PTE_PPN_LSB + PPN_W;

  logic v, r, w, x, rsv_bad, perm_ok, misalign;
  logic [PPN_W-1:0] lowmask;

  assign ppn   = pte[PTE_PPN_LSB +: PPN_W];
  assign flags = pte[PTE_FLAG_W-1:0];

  always_comb begin
    v = pte[0];
    r = pte[1];
    w = pte[2];
    x = pte[3];
    rsv_bad  = |pte[PTE_W-1:RSV_LSB];
    lowmask  = ~({PPN_W{1'b1}} << (IDX_W * int'(lvl)));
    misalign = |(ppn & lowmask);
    is_ptr   = !r && !w && !x;
    unique case (acc)
      ACC_LOAD:  perm_ok = r;
      ACC_STORE: perm_ok = w;
      ACC_FETCH: perm_ok = x;
      default:   perm_ok = 1'b0;
    endcase
    fault = !v || (w && !r) || rsv_bad ||
            (is_ptr && (lvl == '0)) ||
            (!is_ptr && (misalign || !perm_ok));
    leaf_ppn = (ppn & ~lowmask) | (vpn & lowmask);
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 56,
  parameter int PTE_W = 64,
  parameter int IDX_W = 9,
  parameter int ROOT_EXTRA = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [1:0]                 req_acc,
  input  logic                       req_five,
  input  logic                       req_guest,
  input  logic [PA_W-PG_OFF_W-1:0]   req_root,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [PA_W-1:0]            mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [PTE_W-1:0]           mem_rsp_data,
  output logic                       rsp_valid,
  output logic                       rsp_pf,
  output logic                       rsp_gpf,
  output logic [PA_W-1:0]            rsp_paddr,
  output logic [PTE_FLAG_W-1:0]      rsp_flags,
  output logic [2:0]                 rsp_level
);
  localparam int OFF_W = PG_OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int LVL_W = 3;
  localparam int ROOT_IDX_W = IDX_W + ROOT_EXTRA;
  localparam int TOP4 = OFF_W + 4*IDX_W;
  localparam logic [LVL_W-1:0] LVL_TOP5 = LVL_W'(4);
  localparam logic [LVL_W-1:0] LVL_TOP4 = LVL_W'(3);
  localparam logic [ROOT_IDX_W-1:0] NARROW_MASK = ROOT_IDX_W'({IDX_W{1'b1}});

  // Entry address: table base plus index scaled by the 8-byte entry size.
  function automatic logic [PA_W-1:0] pte_addr(input logic [PPN_W-1:0] base,
                                                input logic [VA_W-1:0]  va,
                                                input logic [LVL_W-1:0] lvl,
                                                input logic             wide);
    logic [ROOT_IDX_W-1:0] idx;
    idx = ROOT_IDX_W'(va >> (OFF_W + IDX_W * int'(lvl))) &
          (wide ? {ROOT_IDX_W{1'b1}} : NARROW_MASK);
    return {base, {OFF_W{1'b0}}} + PA_W'({idx, 3'b000});
  endfunction

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             guest_q;
  logic [LVL_W-1:0] lvl_q;

  logic             range_ok;
  logic             e_ptr, e_fault;
  logic [PPN_W-1:0] e_ppn, e_leaf;
  logic [PTE_FLAG_W-1:0] e_flags;
  logic             accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  pgwalk_range #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ROOT_EXTRA(ROOT_EXTRA)
  ) i_range (
    .hi   (req_vaddr[VA_W-1:TOP4-1]),
    .five (req_five),
    .guest(req_guest),
    .ok   (range_ok)
  );

  pgwalk_pte_eval #(
    .PA_W(PA_W), .PTE_W(PTE_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) i_eval (
    .pte     (mem_rsp_data),
    .lvl     (lvl_q),
    .acc     (acc_q),
    .vpn     (va_q[PA_W-1:OFF_W]),
    .is_ptr  (e_ptr),
    .fault   (e_fault),
    .ppn     (e_ppn),
    .leaf_ppn(e_leaf),
    .flags   (e_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      va_q          <= '0;
      acc_q         <= '0;
      guest_q       <= 1'b0;
      lvl_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_pf        <= 1'b0;
      rsp_gpf       <= 1'b0;
      rsp_paddr     <= '0;
      rsp_flags     <= '0;
      rsp_level     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          va_q    <= req_vaddr;
          acc_q   <= req_acc;
          guest_q <= req_guest;
          lvl_q   <= req_five ? LVL_TOP5 : LVL_TOP4;
          if (!range_ok) begin
            rsp_valid <= 1'b1;
            rsp_pf    <= !req_guest;
            rsp_gpf   <= req_guest;
            rsp_paddr <= '0;
            rsp_flags <= '0;
            rsp_level <= '0;
            st        <= ST_DONE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= pte_addr(req_root, req_vaddr,
                                      req_five ? LVL_TOP5 : LVL_TOP4, req_guest);
            st            <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          st            <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          if (e_fault) begin
            rsp_valid <= 1'b1;
            rsp_pf    <= !guest_q;
            rsp_gpf   <= guest_q;
            rsp_paddr <= '0;
            rsp_flags <= '0;
            rsp_level <= '0;
            st        <= ST_DONE;
          end else if (e_ptr) begin
            lvl_q         <= lvl_q - 1'b1;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= pte_addr(e_ppn, va_q, lvl_q - 1'b1, 1'b0);
            st            <= ST_REQ;
          end else begin
            rsp_valid <= 1'b1;
            rsp_pf    <= 1'b0;
            rsp_gpf   <= 1'b0;
            rsp_paddr <= {e_leaf, va_q[OFF_W-1:0]};
            rsp_flags <= e_flags;
            rsp_level <= lvl_q;
            st        <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // A refused read request keeps its valid and address.
  p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // The result strobe lasts a single cycle.
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // Once a request is taken, no other is taken in the next cycle.
  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // Fault kinds never appear together.
  p_fault_kind_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_pf && rsp_gpf));

  // A range violation answers at once without touching memory.
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    accept && !range_ok |=> rsp_valid && !mem_req_valid && (rsp_pf || rsp_gpf));

  // No read request is outstanding while the result is presented.
  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);
endmodule

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_five = 1'b1;
  logic        req_guest = 1'b0;
  logic [43:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_pf, rsp_gpf;
  logic [55:0] rsp_paddr;
  logic [9:0]  rsp_flags;
  logic [2:0]  rsp_level;

  int checks = 0;
  int errors = 0;
  int n_reads = 0;

  always #5 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_five(req_five),
    .req_guest(req_guest), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_pf(rsp_pf),
    .rsp_gpf(rsp_gpf), .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags),
    .rsp_level(rsp_level)
  );

  // Sparse memory model: answers the cycle after it accepts a read.
  logic [63:0] pmem [logic [55:0]];
  always @(posedge clk) begin
    if (rst) mem_rsp_valid <= 1'b0;
    else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_data <= pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 64'h0;
        n_reads      <= n_reads + 1;
      end
    end
  end

  function automatic logic [63:0] ptr(input logic [43:0] p);
    return {10'h0, p, 10'h001};
  endfunction
  function automatic logic [63:0] leaf(input logic [43:0] p, input logic [9:0] f);
    return {10'h0, p, f};
  endfunction
  task automatic put(input logic [43:0] tbl, input int idx, input logic [63:0] val);
    pmem[{tbl, 12'h000} + 56'(idx * 8)] = val;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [4:0]  tag;
    logic [63:0] va;
    logic [1:0]  acc;
    logic        five;
    logic        guest;
    logic [43:0] root;
    logic        pf;
    logic        gpf;
    logic [55:0] pa;
    logic [9:0]  flags;
    logic [2:0]  lvl;
    logic [3:0]  reads;
  } vec_t;

  localparam vec_t VECS [16] = '{
    // R1: full five-level walk to a 4 KiB page
    '{5'd1, 64'h0001_0100_C080_5ABC, 2'd0, 1'b1, 1'b0, 44'h100, 1'b0, 1'b0, 56'h00_0000_5555_5ABC, 10'h0C7, 3'd0, 4'd5},
    // R7: fetch without X
    '{5'd7, 64'h0001_0100_C080_5ABC, 2'd2, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd5},
    // R7: store with W
    '{5'd7, 64'h0001_0100_C080_5ABC, 2'd1, 1'b1, 1'b0, 44'h100, 1'b0, 1'b0, 56'h00_0000_5555_5ABC, 10'h0C7, 3'd0, 4'd5},
    // R6: 2 MiB leaf, low fields from the address
    '{5'd6, 64'h0001_0100_C0DF_3123, 2'd2, 1'b1, 1'b0, 44'h100, 1'b0, 1'b0, 56'h00_0000_777F_3123, 10'h00B, 3'd1, 4'd4},
    // R6: misaligned 2 MiB leaf
    '{5'd6, 64'h0001_0100_C0E0_0000, 2'd0, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd4},
    // R4: invalid entry
    '{5'd4, 64'h0001_0100_C100_0000, 2'd0, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd4},
    // R4: W without R
    '{5'd4, 64'h0001_0100_C120_0000, 2'd0, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd4},
    // R5: pointer at the lowest level
    '{5'd5, 64'h0001_0100_C080_6000, 2'd0, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd5},
    // R2: bit 57 differs from bit 56
    '{5'd2, 64'h0201_0100_C080_5ABC, 2'd0, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd0},
    // R6: 256 TiB leaf at the root, upper-half address
    '{5'd6, 64'hFFFF_1234_5678_9ABC, 2'd0, 1'b1, 1'b0, 44'h100, 1'b0, 1'b0, 56'h12_1234_5678_9ABC, 10'h003, 3'd4, 4'd1},
    // R3: four-level walk
    '{5'd3, 64'h0000_0080_8060_6321, 2'd0, 1'b0, 1'b0, 44'h100, 1'b0, 1'b0, 56'h00_0000_7760_0321, 10'h00B, 3'd0, 4'd4},
    // R3: four-level range violation (bit 48 set, bit 47 clear)
    '{5'd3, 64'h0001_0100_C080_5ABC, 2'd0, 1'b0, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd0},
    // R8: guest root with 11-bit index, leaf at root
    '{5'd8, 64'h0405_0000_0000_0ABC, 2'd1, 1'b1, 1'b1, 44'h200, 1'b0, 1'b0, 56'h07_0000_0000_0ABC, 10'h00F, 3'd4, 4'd1},
    // R8: guest address bit 59 set
    '{5'd8, 64'h0805_0000_0000_0ABC, 2'd0, 1'b1, 1'b1, 44'h200, 1'b0, 1'b1, 56'h0, 10'h0, 3'd0, 4'd0},
    // R8: guest permission fault
    '{5'd8, 64'h0406_0000_0000_0ABC, 2'd1, 1'b1, 1'b1, 44'h200, 1'b0, 1'b1, 56'h0, 10'h0, 3'd0, 4'd1},
    // R4: reserved bit set in a leaf
    '{5'd4, 64'h0001_0100_C140_0000, 2'd0, 1'b1, 1'b0, 44'h100, 1'b1, 1'b0, 56'h0, 10'h0, 3'd0, 4'd4}
  };

  // stall: cycles the memory refuses the first read; busy: cycles a second request is held.
  task automatic run(input vec_t v, input int stall, input int busy);
    int cyc;
    int base;
    int due;
    string t;
    t = $sformatf("R%0d", v.tag);
    @(negedge clk);
    req_vaddr = v.va; req_acc = v.acc; req_five = v.five;
    req_guest = v.guest; req_root = v.root; req_valid = 1'b1;
    if (stall > 0) mem_req_ready = 1'b0;
    base = n_reads;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc <= busy) begin
        chk(req_ready == 1'b0, "R9 busy ready", 64'(req_ready), 64'h0);
        req_vaddr = 64'h0201_0000_0000_0000;
      end else req_valid = 1'b0;
      if (cyc <= stall) begin
        chk(mem_req_valid && mem_req_addr == 56'h10_0008, "R10 held root read",
            64'(mem_req_addr), 64'h10_0008);
        if (cyc == stall) mem_req_ready = 1'b1;
      end
      if (rsp_valid || cyc > 200) break;
    end
    req_valid = 1'b0;
    due = 1 + 2 * int'(v.reads) + ((stall > 0) ? stall - 1 : 0);
    chk(rsp_valid == 1'b1, {t, " strobe"}, 64'(rsp_valid), 64'h1);
    chk(cyc == due, "R12 latency", 64'(cyc), 64'(due));
    chk(rsp_pf == v.pf, {t, " page fault"}, 64'(rsp_pf), 64'(v.pf));
    chk(rsp_gpf == v.gpf, {t, " guest fault"}, 64'(rsp_gpf), 64'(v.gpf));
    chk(n_reads - base == int'(v.reads), {t, " reads"}, 64'(n_reads - base), 64'(v.reads));
    if (!v.pf && !v.gpf) begin
      chk(rsp_paddr == v.pa, {t, " paddr"}, 64'(rsp_paddr), 64'(v.pa));
      chk(rsp_flags == v.flags, "R7 flags", 64'(rsp_flags), 64'(v.flags));
      chk(rsp_level == v.lvl, "R6 level", 64'(rsp_level), 64'(v.lvl));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 single strobe", 64'(rsp_valid), 64'h0);
    repeat (4) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R9 no extra activity",
          64'({rsp_valid, mem_req_valid}), 64'h0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    put(44'h100, 1, ptr(44'h101));
    put(44'h101, 2, ptr(44'h102));
    put(44'h102, 3, ptr(44'h103));
    put(44'h103, 4, ptr(44'h104));
    put(44'h104, 5, leaf(44'h55555, 10'h0C7));
    put(44'h103, 6, leaf(44'h77600, 10'h00B));
    put(44'h103, 7, leaf(44'h77601, 10'h00B));
    put(44'h103, 9, leaf(44'h55555, 10'h005));
    put(44'h103, 10, leaf(44'h55555, 10'h00B) | 64'h1000_0000_0000_0000);
    put(44'h104, 6, ptr(44'h105));
    put(44'h100, 511, leaf(44'h120_0000_0000, 10'h003));
    put(44'h200, 1029, leaf(44'h070_0000_0000, 10'h00F));
    put(44'h200, 1030, leaf(44'h070_0000_0000, 10'h003));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: state after reset
    chk(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'h1);
    chk(rsp_valid == 1'b0, "R11 no strobe", 64'(rsp_valid), 64'h0);
    chk(mem_req_valid == 1'b0, "R11 no read", 64'(mem_req_valid), 64'h0);

    for (int i = 0; i < 16; i++) run(VECS[i], 0, 0);

    // R10: root read refused for two edges (root address checks R1)
    run(VECS[0], 3, 0);
    // R9: second request held for three cycles while walking
    run(VECS[0], 0, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule